// File: doc/BRIEF.md
# Multi-Mode Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: a line sync, a frame sync, a data-enable strobe and the current pixel column and row. A 3-bit resolution code picks one of several built-in timing sets. Each set fixes the active area and the front and back blanking on both axes. Both sync pulses are one unit wide: one clock on the line axis and one line on the frame axis. Pixel data is meant to be launched on the rising clock edge, and every output changes only on that edge.

The code is taken into the running timing only at the last pixel of the last line of a frame, so a frame never mixes two timing sets. While standby is high, or while the stored code is illegal, the raster is halted at column 0, row 0. In that state the code is taken again on every clock, so a new mode applies as soon as scanning starts. Two codes belong to dual-scan modes, which the panel upscales. The block only supplies their input timing, and one of them shares its timing set with an ordinary mode. A parameter inverts the polarity of the three strobes.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset, with standby high, column and row read 0, the three strobes are inactive and `mode_ok` reflects the code being applied.
- R2: Codes 7, 6, 5 and 4 give, as active width/height, line blanking front/back and frame blanking front/back: 7 = 800x480, 40/216, 10/35; 6 = 640x480, 24/136, 18/27; 5 = 480x272, 2/43, 2/12; 4 = 480x640, 2/43, 4/8. The line total is active + front + 1 + back.
- R3: Code 0 (dual-scan, small input) gives 400x240 with line blanking 20/108 and frame blanking 2/20.
- R4: Code 1 (dual-scan) runs exactly the code 5 timing set and reports `mode_ok` high.
- R5: Codes 2 and 3 are illegal. `mode_ok` reads 0, the strobes stay inactive and column/row stay 0 even with standby low.
- R6: The line sync is active for exactly one clock, at column = active width + line front blanking. The frame sync is active for the whole of row = active height + frame front blanking.
- R7: Data enable is active exactly when column < active width and row < active height.
- R8: The column counts 0 to line total − 1 and wraps. The row advances at each wrap and returns to 0 after the last row.
- R9: A code change made in mid-frame takes effect only at column 0, row 0 of the next frame. Until then the old timing continues.
- R10: While standby is high, the strobes are inactive at once, and column and row read 0 from the following clock on. The first clock after standby falls shows column 0, row 0.
- R11: With `ACTIVE_LOW` set, each of the three strobes is the complement of its active-high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Halts and blanks the raster |
| res_code | input | 3 | Resolution code |
| line_sync | output | 1 | Horizontal sync strobe |
| frame_sync | output | 1 | Vertical sync strobe |
| pix_en | output | 1 | Data enable strobe |
| col | output | 11 | Current column |
| row | output | 11 | Current row |
| mode_ok | output | 1 | Stored code is legal |

## Verification
The hardest case to reach is the frame-boundary switch. The code must change while a frame is running, and the effect shows only after a whole frame of the smallest mode, about 139 thousand clocks. The stimulus starts code 0, changes the code to 1 about a thousand clocks in, and places scoreboard entries at the old frame's last pixel and at the new frame's first line. A line length of 529 before the boundary and 526 after it proves when the change took effect. The frame sync and the data-enable edges of that same long frame cover the row-based timing.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int CW     = 11;
    localparam int CODE_W = 3;
    localparam int SYNC_W = 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CW-1:0]     cnt_t;

    typedef struct packed {
        cnt_t hact;
        cnt_t hfp;
        cnt_t hbp;
        cnt_t vact;
        cnt_t vfp;
        cnt_t vbp;
    } timing_t;
endpackage

// File: rtl/ptg_mode_rom.sv
module ptg_mode_rom
    import ptg_pkg::*;
(
    input  code_t   code_i,
    output timing_t tim_o,
    output logic    legal_o
);
    function automatic timing_t mk(input int ha, input int hf, input int hb,
                                   input int va, input int vf, input int vb);
        timing_t t;
        t.hact = cnt_t'(ha);
        t.hfp  = cnt_t'(hf);
        t.hbp  = cnt_t'(hb);
        t.vact = cnt_t'(va);
        t.vfp  = cnt_t'(vf);
        t.vbp  = cnt_t'(vb);
        return t;
    endfunction

    always_comb begin
        legal_o = 1'b1;
        unique case (code_i)
            3'd7:        tim_o = mk(800, 40, 216, 480, 10, 35);
            3'd6:        tim_o = mk(640, 24, 136, 480, 18, 27);
            3'd5, 3'd1:  tim_o = mk(480,  2,  43, 272,  2, 12);
            3'd4:        tim_o = mk(480,  2,  43, 640,  4,  8);
            3'd0:        tim_o = mk(400, 20, 108, 240,  2, 20);
            default: begin
                tim_o   = '0;
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ptg_scan.sv
module ptg_scan
    import ptg_pkg::*;
#(
    parameter code_t RESET_CODE = 3'd7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  standby,
    input  code_t code_i,
    output cnt_t  h_o,
    output cnt_t  v_o,
    output cnt_t  hact_o,
    output cnt_t  vact_o,
    output cnt_t  hs_at_o,
    output cnt_t  vs_at_o,
    output logic  legal_o,
    output logic  run_o
);
    typedef struct packed {
        code_t mode;
        cnt_t  h;
        cnt_t  v;
    } scan_t;

    scan_t   st_d, st_q;
    timing_t tim;
    logic    legal;
    cnt_t    htot, vtot;
    logic    h_last, v_last, frame_end, run, load;

    ptg_mode_rom u_rom (
        .code_i (st_q.mode),
        .tim_o  (tim),
        .legal_o(legal)
    );

    always_comb begin
        htot      = tim.hact + tim.hfp + cnt_t'(SYNC_W) + tim.hbp;
        vtot      = tim.vact + tim.vfp + cnt_t'(SYNC_W) + tim.vbp;
        h_last    = (st_q.h == htot - cnt_t'(1));
        v_last    = (st_q.v == vtot - cnt_t'(1));
        frame_end = h_last && v_last;
        run       = !standby && legal;
        load      = !run || frame_end;

        st_d = st_q;
        if (!run) begin
            st_d.h = '0;
            st_d.v = '0;
        end else if (h_last) begin
            st_d.h = '0;
            st_d.v = v_last ? '0 : st_q.v + cnt_t'(1);
        end else begin
            st_d.h = st_q.h + cnt_t'(1);
        end
        if (load) st_d.mode = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: RESET_CODE, h: '0, v: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign h_o     = st_q.h;
    assign v_o     = st_q.v;
    assign hact_o  = tim.hact;
    assign vact_o  = tim.vact;
    assign hs_at_o = tim.hact + tim.hfp;
    assign vs_at_o = tim.vact + tim.vfp;
    assign legal_o = legal;
    assign run_o   = run;

    assert_col_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.h < htot) && (st_q.v < vtot));
    assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.h == '0) && (st_q.v == '0));
    assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> $stable(st_q.mode));
    assert_illegal_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (st_q.h == '0));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter logic  ACTIVE_LOW = 1'b0,
    parameter code_t RESET_CODE = 3'd7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic [2:0]    res_code,
    output logic          line_sync,
    output logic          frame_sync,
    output logic          pix_en,
    output logic [CW-1:0] col,
    output logic [CW-1:0] row,
    output logic          mode_ok
);
    cnt_t h, v, hact, vact, hs_at, vs_at;
    logic legal, run;
    logic hs_raw, vs_raw, de_raw;

    ptg_scan #(.RESET_CODE(RESET_CODE)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .standby(standby),
        .code_i (res_code),
        .h_o    (h),
        .v_o    (v),
        .hact_o (hact),
        .vact_o (vact),
        .hs_at_o(hs_at),
        .vs_at_o(vs_at),
        .legal_o(legal),
        .run_o  (run)
    );

    always_comb begin
        hs_raw = run && (h >= hs_at) && (h < hs_at + cnt_t'(SYNC_W));
        vs_raw = run && (v >= vs_at) && (v < vs_at + cnt_t'(SYNC_W));
        de_raw = run && (h < hact) && (v < vact);
    end

    assign line_sync  = hs_raw ^ ACTIVE_LOW;
    assign frame_sync = vs_raw ^ ACTIVE_LOW;
    assign pix_en     = de_raw ^ ACTIVE_LOW;
    assign col        = h;
    assign row        = v;
    assign mode_ok    = legal;

    assert_hsync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_raw |=> !hs_raw);
    assert_vsync_starts_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_raw) |-> (col == '0));
    assert_de_outside_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !hs_raw && !vs_raw);
    assert_standby_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !de_raw && !hs_raw && !vs_raw);
endmodule

// File: tb/panel_timing_gen_test.sv
module panel_timing_gen_test;
    import ptg_pkg::*;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        longint when;
        int     x, y;
        bit     de, hs, vs, ok;
        string  tag;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, standby = 1'b1;
    logic [2:0] code = 3'd0;
    logic hs, vs, de, ok, hs_n, vs_n, de_n, ok_n;
    logic [CW-1:0] x, y, x_n, y_n;

    item_t  q[$];
    longint cyc = 0;
    longint t0  = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .res_code(code),
        .line_sync(hs), .frame_sync(vs), .pix_en(de),
        .col(x), .row(y), .mode_ok(ok));

    panel_timing_gen #(.ACTIVE_LOW(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .standby(standby), .res_code(code),
        .line_sync(hs_n), .frame_sync(vs_n), .pix_en(de_n),
        .col(x_n), .row(y_n), .mode_ok(ok_n));

    // timing sets written from R2, R3, R4
    function automatic void tset(input int c, output int t[6], output bit legal);
        legal = 1;
        case (c)
            7: t = '{800, 40, 216, 480, 10, 35};
            6: t = '{640, 24, 136, 480, 18, 27};
            5, 1: t = '{480, 2, 43, 272, 2, 12};
            4: t = '{480, 2, 43, 640, 4, 8};
            0: t = '{400, 20, 108, 240, 2, 20};
            default: begin t = '{0, 0, 0, 0, 0, 0}; legal = 0; end
        endcase
    endfunction

    function automatic item_t mk(input int c, input longint n, input longint when,
                                 input string tag);
        item_t it;
        int t[6];
        bit legal;
        int ht, vt;
        tset(c, t, legal);
        it.when = when;
        it.tag  = tag;
        it.ok   = legal;
        if (!legal) begin
            it.x = 0; it.y = 0; it.de = 0; it.hs = 0; it.vs = 0;
        end else begin
            ht = t[0] + t[1] + 1 + t[2];
            vt = t[3] + t[4] + 1 + t[5];
            it.x  = int'(n % ht);
            it.y  = int'((n / ht) % vt);
            it.de = (it.x < t[0]) && (it.y < t[3]);
            it.hs = (it.x == t[0] + t[1]);
            it.vs = (it.y == t[3] + t[4]);
        end
        return it;
    endfunction

    function automatic item_t blank(input bit okv, input longint when, input string tag);
        item_t it;
        it.when = when; it.tag = tag; it.ok = okv;
        it.x = 0; it.y = 0; it.de = 0; it.hs = 0; it.vs = 0;
        return it;
    endfunction

    // monitor: pops expected items at their sample cycle
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (q.size() > 0 && q[0].when <= cyc) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (e.when < cyc || int'(x) != e.x || int'(y) != e.y || de != e.de ||
                hs != e.hs || vs != e.vs || ok != e.ok) begin
                errors++;
                $display("FAIL %s @%0d: got x=%0d y=%0d de=%0b hs=%0b vs=%0b ok=%0b exp x=%0d y=%0d de=%0b hs=%0b vs=%0b ok=%0b",
                         e.tag, e.when, x, y, de, hs, vs, ok, e.x, e.y, e.de, e.hs, e.vs, e.ok);
            end
            checks++;
            if (de_n != !e.de || hs_n != !e.hs || vs_n != !e.vs) begin
                errors++;
                $display("FAIL R11 @%0d: got de=%0b hs=%0b vs=%0b exp de=%0b hs=%0b vs=%0b",
                         e.when, de_n, hs_n, vs_n, !e.de, !e.hs, !e.vs);
            end
        end
    end

    task automatic push(input item_t it);
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic start(input int c);
        @(posedge clk); #1;
        standby = 1'b1;
        code    = 3'(c);
        repeat (2) @(posedge clk);
        #1 standby = 1'b0;
        t0 = cyc + 1;
    endtask

    task automatic line_checks(input int c, input string tag);
        int t[6];
        bit legal;
        int ht;
        tset(c, t, legal);
        ht = t[0] + t[1] + 1 + t[2];
        start(c);
        push(mk(c, 0,                 t0,                     tag));
        push(mk(c, t[0] - 1,          t0 + t[0] - 1,          tag));
        push(mk(c, t[0],              t0 + t[0],              tag));
        push(mk(c, t[0] + t[1],       t0 + t[0] + t[1],       {tag, " R6"}));
        push(mk(c, t[0] + t[1] + 1,   t0 + t[0] + t[1] + 1,   {tag, " R6"}));
        push(mk(c, ht - 1,            t0 + ht - 1,            {tag, " R8"}));
        push(mk(c, ht,                t0 + ht,                {tag, " R8"}));
        push(mk(c, ht + t[0] - 1,     t0 + ht + t[0] - 1,     {tag, " R7"}));
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint frame;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state under standby, code 0 legal
        push(blank(1, cyc + 1, "R1 reset"));
        drain();

        // R5: illegal codes under standby and while scanning
        @(posedge clk); #1 code = 3'd2;
        push(blank(0, cyc + 2, "R5 code2"));
        drain();
        start(3);
        push(blank(0, t0,       "R5 code3"));
        push(blank(0, t0 + 900, "R5 code3 running"));
        drain();

        // R2, R3, R4 line timing per code
        line_checks(7, "R2 code7");
        line_checks(6, "R2 code6");
        line_checks(5, "R2 code5");
        line_checks(4, "R2 code4");
        line_checks(0, "R3 code0");
        line_checks(1, "R4 code1");

        // R9: full frame of code 0, code changed to 1 in mid-frame
        start(0);
        frame = 529 * 263;
        push(mk(0, 10 * 529,       t0 + 10 * 529,       "R8 row10"));
        push(mk(0, 239 * 529 + 399, t0 + 239 * 529 + 399, "R7 last active"));
        push(mk(0, 240 * 529,      t0 + 240 * 529,      "R7 first blank row"));
        push(mk(0, 242 * 529,      t0 + 242 * 529,      "R6 vsync start"));
        push(mk(0, 242 * 529 + 528, t0 + 242 * 529 + 528, "R6 vsync end of line"));
        push(mk(0, 243 * 529,      t0 + 243 * 529,      "R6 vsync off"));
        push(mk(0, frame - 1,      t0 + frame - 1,      "R9 old timing kept"));
        push(mk(1, 0,              t0 + frame,          "R9 new frame start"));
        push(mk(1, 482,            t0 + frame + 482,    "R9 R4 new hsync"));
        push(mk(1, 526,            t0 + frame + 526,    "R9 R4 new line length"));
        repeat (1000) @(posedge clk);
        #1 code = 3'd1;
        drain();

        // R10: standby in mid-line on row 1
        @(posedge clk); #1 standby = 1'b1;
        push(blank(1, cyc + 2, "R10 standby clears"));
        drain();

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule